// File: doc/BRIEF.md
# Ring and Johnson Sequence Counter

This block is a shift-register sequence generator built from a chain of D flip-flops on one clock. Each stage takes the value of the stage above it, and the top stage takes a feedback bit from the bottom stage. A static mode input selects the kind of feedback. With direct feedback the block is a ring counter: one 1 travels through the register and the output is one-hot. With inverted feedback it is a Johnson (twisted-ring) counter: a run of ones fills the register from the top and then drains out, which gives a sequence of 2·WIDTH states.

An active-low start/reset input puts the register at the starting value for the selected mode. In ring mode the top stage is set and the rest are cleared. In Johnson mode every stage is cleared. Reset takes effect at once without a clock. Its release passes through a two-stage synchronizer, so counting starts on a clock edge. The register width is the parameter `WIDTH` (default 4, minimum 2). The output is the register contents, with the top stage on the MSB. Recovery from illegal states is not provided.

Top module: `seqctr_top`

## Requirements
- R1: While `rst_ni` is low in ring mode (`mode_i` = 0), `state_o` holds only its MSB set (4-bit: 1000).
- R2: While `rst_ni` is low in Johnson mode (`mode_i` = 1), `state_o` is all zeros.
- R3: In ring mode each rising edge moves every bit one place toward the LSB, and the old LSB enters the MSB. The 4-bit sequence is 1000, 0100, 0010, 0001, then 1000 again.
- R4: In Johnson mode each rising edge moves every bit one place toward the LSB, and the inverse of the old LSB enters the MSB. The 4-bit sequence is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, then 0000 again.
- R5: The sequence returns to its starting value after exactly WIDTH edges in ring mode and after exactly 2·WIDTH edges in Johnson mode, and not sooner.
- R6: Driving `rst_ni` low sets `state_o` to the mode's starting value at once, with no clock edge needed.
- R7: After `rst_ni` rises, `state_o` keeps the starting value through the first two rising edges and takes its first step on the third.
- R8: R1 to R7 hold for any `WIDTH` of 2 or more, including a width other than 4.
- R9: `mode_i` changes only while reset is applied. Once counting has started it stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all stages |
| rst_ni | input | 1 | Active-low start/reset; asserts asynchronously, released synchronously |
| mode_i | input | 1 | 0 = ring feedback, 1 = Johnson (inverted) feedback; static outside reset |
| state_o | output | WIDTH | Register contents, MSB is the first stage |

## Verification
The hardest situation to reach from the ports is the exact point where counting starts after reset. The register holds its starting value through two synchronizer edges before it moves, so a check that is one cycle early or late looks like a wrong sequence. The stimulus releases reset at a falling edge and samples on each later falling edge, with the first step expected on the third rising edge. It also asserts reset between clock edges to show that the register loads at once. Runs with random mode and random length, at width 4 and width 7, follow directed passes over the full cycle of each mode. Each run re-enters reset partway through a sequence.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

  typedef enum logic {
    MODE_RING    = 1'b0,
    MODE_JOHNSON = 1'b1
  } seq_mode_e;

endpackage

// File: rtl/seqctr_rst_sync.sv
module seqctr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic meta_q;
  logic sync_q;

  // asserts at once, releases after two rising edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

endmodule

// File: rtl/seqctr_feedback.sv
module seqctr_feedback
  import seqctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  seq_mode_e        mode_i,
  input  logic             tail_i,
  output logic             fb_o,
  output logic [WIDTH-1:0] seed_o
);

  always_comb begin
    seed_o = '0;
    if (mode_i == MODE_RING) begin
      fb_o              = tail_i;
      seed_o[WIDTH-1]   = 1'b1;
    end else begin
      fb_o              = ~tail_i;
    end
  end

endmodule

// File: rtl/seqctr_stage.sv
module seqctr_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic d_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  always_comb begin
    q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= seed_i;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/seqctr_top.sv
module seqctr_top
  import seqctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  output logic [WIDTH-1:0] state_o
);

  localparam int LastIdx = WIDTH - 1;

  seq_mode_e        mode;
  logic             rst_sync_n;
  logic             fb_bit;
  logic [WIDTH-1:0] seed_vec;
  logic [WIDTH-1:0] stage_q;

  assign mode = seq_mode_e'(mode_i);

  seqctr_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  seqctr_feedback #(.WIDTH(WIDTH)) u_feedback (
    .mode_i (mode),
    .tail_i (stage_q[0]),
    .fb_o   (fb_bit),
    .seed_o (seed_vec)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic d_in;
    if (i == LastIdx) begin : g_head
      assign d_in = fb_bit;
    end else begin : g_body
      assign d_in = stage_q[i+1];
    end
    seqctr_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .seed_i (seed_vec[i]),
      .d_i    (d_in),
      .q_o    (stage_q[i])
    );
  end

  assign state_o = stage_q;

  // R1: ring mode keeps exactly one bit set
  assert_ring_onehot_R1 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_i == 1'b0) |-> ($countones(state_o) == 1));

  // R4: Johnson mode gains or loses exactly one set bit per edge
  assert_johnson_step_R4 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_i == 1'b1) |=> (($countones(state_o) == $countones($past(state_o)) + 1) ||
                          ($countones(state_o) + 1 == $countones($past(state_o)))));

  // R3: lower stages take the old value of the stage above
  assert_chain_shift_R3 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> (state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1])));

  // R2: Johnson reset value is all zeros
  assert_johnson_seed_R2 : assert property (@(posedge clk_i)
    (!rst_sync_n && mode_i == 1'b1) |-> (state_o == '0));

  // R9: mode is static while counting
  assert_mode_static_R9 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |-> $stable(mode_i));

endmodule

// File: tb/seqctr_top_tb_top.sv
module seqctr_top_tb_top;

  localparam int WA = 4;
  localparam int WB = 7;

  logic          clk;
  logic          rst_n;
  logic          mode;
  logic [WA-1:0] out_a;
  logic [WB-1:0] out_b;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  seqctr_top #(.WIDTH(WA)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode), .state_o (out_a));

  seqctr_top #(.WIDTH(WB)) dut_w7_i (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode), .state_o (out_b));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] seed_of(int w, bit m);
    logic [15:0] s = '0;
    if (!m) s[w-1] = 1'b1;
    return s;
  endfunction

  function automatic logic [15:0] next_of(logic [15:0] s, int w, bit m);
    logic [15:0] n = s >> 1;
    n[w-1] = m ? ~s[0] : s[0];
    return n;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // enter reset between edges, hold, release at a falling edge
  task automatic do_reset(bit m);
    @(negedge clk);
    #3;
    rst_n = 1'b0;
    mode  = m;
    #1;
    check(m ? "R6/R2 async" : "R6/R1 async", 16'(out_a), seed_of(WA, m));
    check("R8 async w7", 16'(out_b), seed_of(WB, m));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 hold", 16'(out_a), seed_of(WA, m));
    check("R7 hold w7", 16'(out_b), seed_of(WB, m));
  endtask

  task automatic run(bit m, int steps);
    logic [15:0] ea = seed_of(WA, m);
    logic [15:0] eb = seed_of(WB, m);
    int pa = m ? 2 * WA : WA;
    int pb = m ? 2 * WB : WB;
    do_reset(m);
    for (int k = 1; k <= steps; k++) begin
      @(negedge clk);
      ea = next_of(ea, WA, m);
      eb = next_of(eb, WB, m);
      check(m ? "R4 step" : "R3 step", 16'(out_a), ea);
      check("R8 step w7", 16'(out_b), eb);
      if (k % pa == 0) check("R5 period", 16'(out_a), seed_of(WA, m));
      else if (out_a == seed_of(WA, m)) check("R5 early", 16'(out_a), ~seed_of(WA, m));
      if (k % pb == 0) check("R5 period w7", 16'(out_b), seed_of(WB, m));
    end
  endtask

  logic [3:0] ring4 [4]  = '{4'b0100, 4'b0010, 4'b0001, 4'b1000};
  logic [3:0] john4 [8]  = '{4'b1000, 4'b1100, 4'b1110, 4'b1111,
                             4'b0111, 4'b0011, 4'b0001, 4'b0000};

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b1;
    mode  = 1'b0;
    #1 rst_n = 1'b0;
    // directed literal sequences, width 4
    do_reset(1'b0);
    check("R1 seed", 16'(out_a), 16'h0008);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 literal", 16'(out_a), 16'(ring4[k]));
    end
    do_reset(1'b1);
    check("R2 seed", 16'(out_a), 16'h0000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R4 literal", 16'(out_a), 16'(john4[k]));
    end
    // full cycles at both widths, both modes
    run(1'b0, 2 * WB);
    run(1'b1, 4 * WB);
    // random modes and lengths, reset cuts each run short
    for (int r = 0; r < 12; r++) begin
      run(1'($urandom_range(0, 1)), int'($urandom_range(1, 30)));
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule